// File: doc/BRIEF.md
# Serial Register-Access Bridge for a Power-Management Device

This block sits on a processor's memory-mapped register bus and gives software access to the 16-bit registers of a remote power-management device over a four-wire serial link. Stores that land in a 4 KiB window at bus offset 0x8000 are queued in a small write queue and sent to the device one frame at a time, strictly in arrival order. Software needs no extra trigger to start a read: it stores the device register address into a read-command register. The bridge then waits until every store queued before that command has gone out, sends the read frame, and captures the 16 returned bits.

The result register combines the returned value, a busy flag and an echo of the 12-bit address that was read, so software can poll one word and confirm it holds the answer it asked for. A separate status word gives the write queue's full and empty flags and a sticky overflow flag for stores that were dropped because the queue was full. The processor side is a plain single-cycle register port with no back-pressure: stores are always taken, and reads return combinationally in the same cycle.

Top module: `pmic_bridge`

## Requirements
- R1: A store with `cpu_addr` in 0x8000..0x8FFF queues the pair {offset = `cpu_addr[11:0]`, data = `cpu_wdata[15:0]`}. A store to any other address that is not a bridge register queues nothing and starts no frame.
- R2: A store to offset 0x0000 (read command) with no read in progress starts a read of device address `cpu_wdata[11:0]`. Bit 31 of the result word (offset 0x0004) reads 1 from the cycle after that store until the read has completed, and then reads 0.
- R3: When bit 31 is 0, bits 15:0 of the result word hold the value the device returned for the last completed read.
- R4: Bits 30:16 of the result word hold the low 12 bits of the last accepted read-command word, with bits 30:28 zero. This field is updated in the cycle after the command is accepted.
- R5: Each frame holds `ser_cs_n` low for exactly 29 bit periods of CLK_DIV clocks each and sends MSB first: a direction bit (1 = read), the 12-bit address, then 16 data bits (zeros for a read). `ser_clk` is high in the second half of each bit period. `ser_miso` is sampled at the end of each of the last 16 bit periods of a read.
- R6: The status word at offset 0x0008 has queue full in bit 11, queue empty in bit 10 and overflow in bit 12. All other bits read 0.
- R7: A window store while the queue is full is dropped and sets the overflow bit. The bit stays set until a store to offset 0x0008 with bit 12 set clears it.
- R8: Queued stores reach the link in the order they were made. A read frame goes out only after every store accepted before its command. Stores accepted after the command go out after the read frame. No frame is sent unless it was requested.
- R9: A read-command store while a read is in progress is ignored. The echoed address and the result are those of the first command, and no extra frame is sent.
- R10: After reset the result word reads 0, the status word reads 0x400, and `ser_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_en | input | 1 | Register access strobe |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Byte offset within the bridge |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, combinational |
| ser_clk | output | 1 | Serial bit clock |
| ser_cs_n | output | 1 | Frame select, active low |
| ser_mosi | output | 1 | Serial data to the device |
| ser_miso | input | 1 | Serial data from the device |

## Verification
The bench builds the bridge with FIFO_DEPTH = 4 and CLK_DIV = 4. A frame then lasts 116 clocks, so five back-to-back window stores fill the queue while the first frame is still on the link, and a sixth store hits the full queue and the overflow path. The short frame length also keeps the ordering scenarios short: stores before and after a read command, and a second command arriving while a read is in progress.

// File: rtl/pmic_bridge_pkg.sv
package pmic_bridge_pkg;
  localparam int SADDR_W = 12;
  localparam int DATA_W  = 16;
  localparam int BUS_AW  = 16;
  localparam int FRAME_W = 1 + SADDR_W + DATA_W;
  localparam int ECHO_W  = 15;

  localparam logic [BUS_AW-1:0] OFS_RDCMD  = 16'h0000;
  localparam logic [BUS_AW-1:0] OFS_RDDATA = 16'h0004;
  localparam logic [BUS_AW-1:0] OFS_FSTS   = 16'h0008;
  localparam int                WIN_SIZE   = 4096;
  localparam logic [BUS_AW-1:0] WIN_BASE   = 16'h8000;
  localparam logic [BUS_AW-1:0] WIN_MASK   = ~BUS_AW'(WIN_SIZE - 1);

  localparam int BUSY_BIT  = 31;
  localparam int OVF_BIT   = 12;
  localparam int FULL_BIT  = 11;
  localparam int EMPTY_BIT = 10;

  typedef struct packed {
    logic [SADDR_W-1:0] addr;
    logic [DATA_W-1:0]  data;
  } wr_entry_t;
endpackage

// File: rtl/pmic_wr_fifo.sv
module pmic_wr_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 28,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign count   = cnt;
  assign dout    = mem[rptr];
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok)  rptr <= bump(rptr);
      if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
      else if (!push_ok && pop_ok) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pmic_ser_engine.sv
module pmic_ser_engine
  import pmic_bridge_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               start_rd,
  input  logic [SADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0]  start_data,
  output logic               active,
  output logic               done,
  output logic [DATA_W-1:0]  rx_data,
  output logic               ser_clk,
  output logic               ser_cs_n,
  output logic               ser_mosi,
  input  logic               ser_miso
);
  localparam int CW      = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int BW      = $clog2(FRAME_W);
  localparam int HALF    = CLK_DIV / 2;
  localparam int RX_FROM = 1 + SADDR_W;

  logic [CW-1:0]      div_q;
  logic [BW-1:0]      bit_q;
  logic [FRAME_W-1:0] sh_q;
  logic [DATA_W-1:0]  rx_q;
  logic               act_q, done_q;
  logic               bit_end;

  assign bit_end = (div_q == CW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      done_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (start) begin
          act_q <= 1'b1;
          div_q <= '0;
          bit_q <= '0;
          sh_q  <= {start_rd, start_addr, start_rd ? {DATA_W{1'b0}} : start_data};
        end
      end else if (bit_end) begin
        div_q <= '0;
        sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
        if (bit_q >= BW'(RX_FROM)) rx_q <= {rx_q[DATA_W-2:0], ser_miso};
        if (bit_q == BW'(FRAME_W - 1)) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign active   = act_q;
  assign done     = done_q;
  assign rx_data  = rx_q;
  assign ser_cs_n = !act_q;
  assign ser_clk  = act_q && (div_q >= CW'(HALF));
  assign ser_mosi = act_q && sh_q[FRAME_W-1];
endmodule

// File: rtl/pmic_bridge.sv
module pmic_bridge
  import pmic_bridge_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CLK_DIV    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_en,
  input  logic        cpu_we,
  input  logic [15:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        ser_clk,
  output logic        ser_cs_n,
  output logic        ser_mosi,
  input  logic        ser_miso
);
  localparam int CW      = $clog2(FIFO_DEPTH + 1);
  localparam int ENTRY_W = $bits(wr_entry_t);

  // bus decode
  logic in_win, wr_win, wr_cmd, wr_sts, push, accept_cmd;
  logic unused_wdata_hi;

  assign in_win          = ((cpu_addr & WIN_MASK) == WIN_BASE);
  assign wr_win          = cpu_en && cpu_we && in_win;
  assign wr_cmd          = cpu_en && cpu_we && (cpu_addr == OFS_RDCMD);
  assign wr_sts          = cpu_en && cpu_we && (cpu_addr == OFS_FSTS);
  assign unused_wdata_hi = ^cpu_wdata[31:DATA_W];

  // write queue
  wr_entry_t     fifo_in, fifo_out;
  logic [ENTRY_W-1:0] fifo_dout;
  logic          fifo_full, fifo_empty, pop;
  logic [CW-1:0] fifo_count;

  assign fifo_in.addr = cpu_addr[SADDR_W-1:0];
  assign fifo_in.data = cpu_wdata[DATA_W-1:0];
  assign fifo_out     = fifo_dout;
  assign push         = wr_win && !fifo_full;

  pmic_wr_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (fifo_in),
    .pop   (pop),
    .dout  (fifo_dout),
    .full  (fifo_full),
    .empty (fifo_empty),
    .count (fifo_count)
  );

  // read command state
  logic               rd_pend, rd_fly, rd_busy, ovf_q;
  logic [SADDR_W-1:0] rd_addr_q;
  logic [DATA_W-1:0]  rd_data_q;
  logic [CW-1:0]      ahead_q;
  logic               launch_wr, launch_rd;
  logic               eng_active, eng_done;
  logic [DATA_W-1:0]  eng_rx;

  assign rd_busy    = rd_pend || rd_fly;
  assign accept_cmd = wr_cmd && !rd_busy;

  // stores queued ahead of a pending read go first; later ones wait
  assign launch_rd = !eng_active && rd_pend && (ahead_q == '0);
  assign launch_wr = !eng_active && !fifo_empty && !launch_rd;
  assign pop       = launch_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend   <= 1'b0;
      rd_fly    <= 1'b0;
      rd_addr_q <= '0;
      rd_data_q <= '0;
      ahead_q   <= '0;
      ovf_q     <= 1'b0;
    end else begin
      if (accept_cmd) begin
        rd_pend   <= 1'b1;
        rd_addr_q <= cpu_wdata[SADDR_W-1:0];
        ahead_q   <= fifo_count - CW'(pop);
      end else if (pop && ahead_q != '0) begin
        ahead_q <= ahead_q - 1'b1;
      end
      if (launch_rd) begin
        rd_pend <= 1'b0;
        rd_fly  <= 1'b1;
      end
      if (eng_done && rd_fly) begin
        rd_fly    <= 1'b0;
        rd_data_q <= eng_rx;
      end
      if (wr_win && fifo_full)                ovf_q <= 1'b1;
      else if (wr_sts && cpu_wdata[OVF_BIT])  ovf_q <= 1'b0;
    end
  end

  pmic_ser_engine #(.CLK_DIV(CLK_DIV)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (launch_wr || launch_rd),
    .start_rd   (launch_rd),
    .start_addr (launch_rd ? rd_addr_q : fifo_out.addr),
    .start_data (fifo_out.data),
    .active     (eng_active),
    .done       (eng_done),
    .rx_data    (eng_rx),
    .ser_clk    (ser_clk),
    .ser_cs_n   (ser_cs_n),
    .ser_mosi   (ser_mosi),
    .ser_miso   (ser_miso)
  );

  // load mux
  always_comb begin
    cpu_rdata = '0;
    if (cpu_en && !cpu_we) begin
      if (cpu_addr == OFS_RDDATA) begin
        cpu_rdata = {rd_busy, (ECHO_W - SADDR_W)'(0), rd_addr_q, rd_data_q};
      end else if (cpu_addr == OFS_FSTS) begin
        cpu_rdata[OVF_BIT]   = ovf_q;
        cpu_rdata[FULL_BIT]  = fifo_full;
        cpu_rdata[EMPTY_BIT] = fifo_empty;
      end
    end
  end
endmodule

// File: rtl/pmic_bridge_chk.sv
module pmic_bridge_chk
  import pmic_bridge_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_en,
  input logic               cpu_we,
  input logic [15:0]        cpu_addr,
  input logic [SADDR_W-1:0] cmd_word,
  input logic               rd_busy,
  input logic [SADDR_W-1:0] rd_echo,
  input logic               fifo_full,
  input logic               fifo_empty,
  input logic               ovf,
  input logic               ser_cs_n,
  input logic               ser_mosi
);
  logic cmd_wr, win_wr;
  assign cmd_wr = cpu_en && cpu_we && (cpu_addr == OFS_RDCMD);
  assign win_wr = cpu_en && cpu_we && ((cpu_addr & WIN_MASK) == WIN_BASE);

  AST_BUSY_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !rd_busy) |=> rd_busy); // R2
  AST_ECHO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !rd_busy) |=> (rd_echo == $past(cmd_word))); // R4
  AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && rd_busy) |=> $stable(rd_echo)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && fifo_full) |=> ovf); // R7
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty)); // R6
  AST_READ_FRAME_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ser_cs_n) && ser_mosi) |-> rd_busy); // R8
endmodule

bind pmic_bridge pmic_bridge_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_en     (cpu_en),
  .cpu_we     (cpu_we),
  .cpu_addr   (cpu_addr),
  .cmd_word   (cpu_wdata[11:0]),
  .rd_busy    (rd_busy),
  .rd_echo    (rd_addr_q),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .ovf        (ovf_q),
  .ser_cs_n   (ser_cs_n),
  .ser_mosi   (ser_mosi)
);

// File: tb/tb_pmic_bridge.sv
`timescale 1ns/1ps
module tb_pmic_bridge;
  localparam int DEPTH = 4;
  localparam int DIV   = 4;
  localparam logic [15:0] A_CMD = 16'h0000, A_DATA = 16'h0004, A_STS = 16'h0008;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cpu_en = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        ser_clk, ser_cs_n, ser_mosi;
  logic        ser_miso = 1'b0;

  pmic_bridge #(.FIFO_DEPTH(DEPTH), .CLK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_en(cpu_en), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .ser_clk(ser_clk), .ser_cs_n(ser_cs_n), .ser_mosi(ser_mosi), .ser_miso(ser_miso)
  );

  int checks = 0, errors = 0;
  bit running = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model: expected device contents and expected frame order
  typedef struct { bit rw; int addr; int data; } op_t;
  op_t expq[$];
  logic [15:0] exp_mem [int];
  logic [15:0] smem [int];

  function automatic logic [15:0] dflt(input int a);
    return 16'(a ^ 32'h5A5A);
  endfunction
  function automatic logic [15:0] exp_rd(input int a);
    return exp_mem.exists(a) ? exp_mem[a] : dflt(a);
  endfunction
  function automatic logic [15:0] slv_rd(input int a);
    return smem.exists(a) ? smem[a] : dflt(a);
  endfunction

  // behavioural device on the serial link
  logic [28:0] s_sh = '0;
  int          s_cnt = 0;
  int          s_low = 0;
  logic [15:0] s_out = '0;

  always @(posedge ser_clk) if (!ser_cs_n) begin
    s_sh = {s_sh[27:0], ser_mosi};
    s_cnt++;
    if (s_cnt == 13 && s_sh[12]) s_out = slv_rd(int'(s_sh[11:0]));
  end

  always @(negedge ser_clk) if (!ser_cs_n && s_cnt >= 13 && s_cnt <= 28 && s_sh[s_cnt-1])
    ser_miso <= s_out[28 - s_cnt];

  always @(negedge clk) if (!ser_cs_n) s_low++;

  always @(posedge ser_cs_n) if (s_cnt != 0) begin
    op_t e;
    chk(s_cnt == 29, "R5", "bits per frame", s_cnt, 29);
    chk(s_low == 29 * DIV, "R5", "select-low clocks", s_low, 29 * DIV);
    if (!s_sh[28]) smem[int'(s_sh[27:16])] = s_sh[15:0];
    if (expq.size() == 0) begin
      chk(1'b0, "R8", "frame with nothing pending", {3'b0, s_sh}, 0);
    end else begin
      e = expq.pop_front();
      chk(s_sh[28] == e.rw, "R5", "direction bit", s_sh[28], e.rw);
      chk(int'(s_sh[27:16]) == e.addr, "R8", "frame address order", s_sh[27:16], e.addr);
      if (!e.rw) chk(int'(s_sh[15:0]) == e.data, "R8", "frame data", s_sh[15:0], e.data);
    end
    s_cnt = 0;
    s_low = 0;
  end

  // compared on every clock: no frame may be on the link when the model expects none
  always @(negedge clk) if (running && expq.size() == 0)
    chk(ser_cs_n === 1'b1, "R8", "link idle when nothing queued", ser_cs_n, 1);

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
    cpu_en = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_en = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [31:0] v);
    cpu_en = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    #1 v = cpu_rdata;
    @(negedge clk);
    cpu_en = 1'b0;
  endtask

  task automatic win_wr(input int off, input int d, input bit drop);
    if (!drop) begin
      exp_mem[off] = 16'(d);
      expq.push_back('{1'b0, off, d & 32'hFFFF});
    end
    bus_wr(16'h8000 + 16'(off), 32'(d));
  endtask

  task automatic wait_idle();
    while (expq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic read_check(input logic [31:0] word, input string req);
    logic [11:0] a;
    logic [15:0] ev;
    logic [31:0] v;
    int n;
    a  = word[11:0];
    ev = exp_rd(int'(a));
    expq.push_back('{1'b1, int'(a), 0});
    bus_wr(A_CMD, word);
    bus_rd(A_DATA, v);
    chk(v[31] == 1'b1, "R2", "busy right after command", v, {1'b1, 31'h0});
    chk(v[30:16] == {3'b0, a}, "R4", "echo while busy", v[30:16], {3'b0, a});
    n = 0;
    while (v[31] && n < 4000) begin
      bus_rd(A_DATA, v);
      n++;
    end
    chk(v[31] == 1'b0, "R2", "busy clears", v, 0);
    chk(v[15:0] == ev, req, "read value", v[15:0], ev);
    chk(v[30:16] == {3'b0, a}, "R4", "echo after completion", v[30:16], {3'b0, a});
  endtask

  logic [31:0] rv;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    running = 1'b1;

    // R10: reset state
    bus_rd(A_DATA, rv);
    chk(rv == 32'h0, "R10", "result word after reset", rv, 32'h0);
    bus_rd(A_STS, rv);
    chk(rv == 32'h400, "R10", "status after reset", rv, 32'h400);
    chk(ser_cs_n == 1'b1, "R10", "select idle after reset", ser_cs_n, 1);

    // R8: stores before a read go first, stores after it go later
    win_wr(12'h010, 16'h1111, 1'b0);
    win_wr(12'h020, 16'h2222, 1'b0);
    expq.push_back('{1'b1, 12'h010, 0});
    bus_wr(A_CMD, 32'h010);
    win_wr(12'h010, 16'h3333, 1'b0);
    bus_rd(A_DATA, rv);
    while (rv[31]) bus_rd(A_DATA, rv);
    chk(rv[15:0] == 16'h1111, "R8", "read sees earlier store only", rv[15:0], 16'h1111);
    read_check(32'h010, "R8");
    read_check(32'h020, "R3");
    wait_idle();

    // R4: echo keeps only the low 12 bits; R3 unwritten register value
    read_check(32'hFFFF_FA7C, "R3");

    // R9: second command during a read is ignored
    expq.push_back('{1'b1, 12'h123, 0});
    bus_wr(A_CMD, 32'h123);
    bus_wr(A_CMD, 32'h456);
    bus_rd(A_DATA, rv);
    chk(rv[30:16] == 15'h123, "R9", "echo keeps first command", rv[30:16], 15'h123);
    while (rv[31]) bus_rd(A_DATA, rv);
    chk(rv[15:0] == dflt(12'h123), "R9", "result of first command", rv[15:0], dflt(12'h123));
    chk(rv[30:16] == 15'h123, "R9", "echo after completion", rv[30:16], 15'h123);
    wait_idle();

    // R1: window bounds
    bus_wr(16'h7FFE, 32'h1234);
    bus_wr(16'h9000, 32'h5678);
    bus_rd(A_STS, rv);
    chk(rv == 32'h400, "R1", "stores outside window not queued", rv, 32'h400);
    win_wr(12'hFFE, 16'hBEEF, 1'b0);
    read_check(32'hFFE, "R1");
    wait_idle();

    // R6, R7: fill the queue and overflow it
    for (int i = 0; i < DEPTH + 1; i++) win_wr(12'h100 + i, 16'hA000 + i, 1'b0);
    win_wr(12'h7EE, 16'hDEAD, 1'b1);
    bus_rd(A_STS, rv);
    chk(rv == 32'h1800, "R7", "full and overflow flags", rv, 32'h1800);
    bus_wr(A_STS, 32'h0);
    bus_rd(A_STS, rv);
    chk(rv[12] == 1'b1, "R7", "overflow sticky without clear bit", rv, 32'h1800);
    bus_wr(A_STS, 32'h1000);
    bus_rd(A_STS, rv);
    chk(rv == 32'h800, "R6", "overflow cleared, still full", rv, 32'h800);
    wait_idle();
    chk(!smem.exists(12'h7EE), "R7", "dropped store never sent", 1, 0);
    bus_rd(A_STS, rv);
    chk(rv == 32'h400, "R6", "empty after drain", rv, 32'h400);
    read_check(32'h104, "R8");
    wait_idle();

    running = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule